// File: doc/BRIEF.md
# Sequential Shift-Add Fixed-Point Multiplier

This block multiplies two sign-magnitude fixed-point numbers on a device that has no combinational multiplier to spare. Each operand is N bits wide. The top bit is the sign, and the remaining N-1 bits hold a magnitude with Q of them fractional. A one-cycle `start` pulse captures both operands. A controller then steps through the multiplier magnitude one bit per clock, adding a left-shifting copy of the multiplicand magnitude into a double-width accumulator. After the last bit, the accumulator is rescaled back to the operand format, and `done` pulses for one cycle.

The controller has three states:
- `ST_IDLE` waits for `start`. The transition `IDLE->RUN` fires on `start` and loads the operands.
- `ST_RUN` performs one shift-add per cycle. It takes `RUN->RUN` while iterations remain and `RUN->PACK` on the iteration with index N-2, which is the last of N-1.
- `ST_PACK` captures the rescaled result, the sign and the overflow flag, raises `done`, and takes `PACK->IDLE` unconditionally.

The result and the overflow flag hold their values until the next `ST_PACK`.

Top module: `fxp_shift_mult`

## Requirements
- R1: With magnitudes ma = a[N-2:0] and mb = b[N-2:0], the result magnitude result[N-2:0] equals floor(ma*mb / 2^Q) mod 2^(N-1). Fraction bits below the kept field are truncated, not rounded.
- R2: The result sign, result[N-1], is the XOR of multiplicand[N-1] and multiplier[N-1] whenever the result magnitude is nonzero.
- R3: A zero result magnitude always gives result[N-1] = 0, including when one operand is negative.
- R4: `overflow` is 1 exactly when ma*mb >= 2^(Q+N-1), that is, when any product bit lies above the kept field. In that case the kept field still holds the wrapped bits.
- R5: `done` is high for exactly one cycle. Counting the rising edge that samples `start` as edge 0, `done` is first seen high after edge N.
- R6: `start` is ignored outside `ST_IDLE`. A pulse during a run changes neither the result nor the time at which `done` appears.
- R7: `result` and `overflow` change only on the edge that raises `done`, and they hold their values in every other cycle.
- R8: While `rst_n` is low, the block is in `ST_IDLE` with `result`, `done` and `overflow` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request that loads both operands while idle |
| multiplicand | input | N | Sign-magnitude operand A |
| multiplier | input | N | Sign-magnitude operand B, consumed one bit per cycle |
| result | output | N | Sign-magnitude product in the operand format |
| done | output | 1 | One-cycle completion pulse |
| overflow | output | 1 | Product magnitude exceeded the kept field |

## Verification
Several properties are checked on every cycle:
- `done` is a single-cycle pulse that lands only when the controller returns to idle.
- The controller never leaves `ST_RUN` before the final iteration, whatever `start` does.
- `result` and `overflow` hold outside the capture cycle.
- A zero magnitude never carries a negative sign.

Only the bench scenarios can show the arithmetic itself: truncation of low fraction bits, the sign rule on mixed operands, wrap and overflow at the top of the range, the exact completion latency, and that a mid-run `start` leaves the product unchanged.

// File: rtl/fxp_mult_pkg.sv
package fxp_mult_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_PACK = 2'd2
    } mult_state_e;

endpackage

// File: rtl/fxp_mult_ctrl.sv
module fxp_mult_ctrl
    import fxp_mult_pkg::*;
#(
    parameter int ITERS = 31
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    output logic        load,
    output logic        step,
    output logic        pack,
    output mult_state_e state
);
    localparam int CNT_W = (ITERS > 1) ? $clog2(ITERS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ITERS - 1);

    mult_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RUN;
            ST_RUN:  if (cnt_q == LAST) state_d = ST_PACK;
            ST_PACK: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and iteration counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RUN) cnt_q <= cnt_q + 1'b1;
            else                   cnt_q <= '0;
        end
    end

    // Output decode
    always_comb begin
        load = 1'b0;
        step = 1'b0;
        pack = 1'b0;
        unique case (state_q)
            ST_IDLE: load = start;
            ST_RUN:  step = 1'b1;
            ST_PACK: pack = 1'b1;
            default: ;
        endcase
    end

    assign state = state_q;

    AST_RUN_NOT_CUT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && cnt_q != LAST) |=> state_q == ST_RUN); // R6
    AST_PACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_PACK |=> state_q == ST_IDLE); // R5

endmodule

// File: rtl/fxp_mult_datapath.sv
module fxp_mult_datapath #(
    parameter int Q = 15,
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic         pack,
    input  logic [N-1:0] op_a,
    input  logic [N-1:0] op_b,
    output logic [N-1:0] result,
    output logic         overflow,
    output logic         done
);
    localparam int M     = N - 1;
    localparam int ACC_W = 2 * M;
    localparam int HI_LO = Q + M;

    logic [ACC_W-1:0] mcand_sh;
    logic [M-1:0]     mplr;
    logic [ACC_W-1:0] acc;
    logic             sign_x;
    logic [M-1:0]     kept;
    logic             hi_any;

    assign kept   = acc[HI_LO-1:Q];
    assign hi_any = |acc[ACC_W-1:HI_LO];

    // Shift-add engine
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mcand_sh <= '0;
            mplr     <= '0;
            acc      <= '0;
            sign_x   <= 1'b0;
        end else if (load) begin
            mcand_sh <= {{(ACC_W-M){1'b0}}, op_a[M-1:0]};
            mplr     <= op_b[M-1:0];
            acc      <= '0;
            sign_x   <= op_a[N-1] ^ op_b[N-1];
        end else if (step) begin
            if (mplr[0]) acc <= acc + mcand_sh;
            mcand_sh <= mcand_sh << 1;
            mplr     <= mplr >> 1;
        end
    end

    // Output capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result   <= '0;
            overflow <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= pack;
            if (pack) begin
                result   <= {sign_x & (|kept), kept};
                overflow <= hi_any;
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5
    AST_ZERO_POS: assert property (@(posedge clk) disable iff (!rst_n)
        (result[N-2:0] == '0) |-> !result[N-1]); // R3
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pack |=> ($stable(result) && $stable(overflow))); // R7

endmodule

// File: rtl/fxp_shift_mult.sv
module fxp_shift_mult
    import fxp_mult_pkg::*;
#(
    parameter int Q = 15,
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [N-1:0] multiplicand,
    input  logic [N-1:0] multiplier,
    output logic [N-1:0] result,
    output logic         done,
    output logic         overflow
);
    localparam int M = N - 1;

    logic        load, step, pack;
    mult_state_e state;

    fxp_mult_ctrl #(.ITERS(M)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .pack  (pack),
        .state (state)
    );

    fxp_mult_datapath #(.Q(Q), .N(N)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .pack     (pack),
        .op_a     (multiplicand),
        .op_b     (multiplier),
        .result   (result),
        .overflow (overflow),
        .done     (done)
    );

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> state == ST_IDLE); // R5

endmodule

// File: tb/fxp_shift_mult_bench.sv
module fxp_shift_mult_bench;
    localparam int Q = 15;
    localparam int N = 32;
    localparam int NV = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [N-1:0] mcand = '0, mplr = '0;
    logic [N-1:0] result;
    logic done, overflow;

    int checks = 0;
    int errors = 0;
    int lat;

    always #5 clk = ~clk;

    fxp_shift_mult #(.Q(Q), .N(N)) u_fxp_shift_mult (
        .clk(clk), .rst_n(rst_n), .start(start),
        .multiplicand(mcand), .multiplier(mplr),
        .result(result), .done(done), .overflow(overflow)
    );

    // {a, b, expected result, expected overflow}
    localparam logic [96:0] VEC [NV] = '{
        {32'h0000_8000, 32'h0000_8000, 32'h0000_8000, 1'b0}, // R1 1.0*1.0
        {32'h0001_0000, 32'h8000_C000, 32'h8001_8000, 1'b0}, // R2 2.0*-1.5
        {32'h8000_4000, 32'h8000_4000, 32'h0000_2000, 1'b0}, // R2 neg*neg
        {32'h0000_0000, 32'h8001_8000, 32'h0000_0000, 1'b0}, // R3 zero*neg
        {32'h4000_0000, 32'h0001_0000, 32'h0000_0000, 1'b1}, // R4 wrap to zero
        {32'hC000_0000, 32'h0001_0000, 32'h0000_0000, 1'b1}, // R3 R4 neg wrap
        {32'h8000_0001, 32'h0000_4000, 32'h0000_0000, 1'b0}, // R1 R3 truncated away
        {32'h0000_0003, 32'h0000_C000, 32'h0000_0004, 1'b0}, // R1 truncation
        {32'h7FFF_FFFF, 32'h0000_8000, 32'h7FFF_FFFF, 1'b0}, // R4 max no ovf
        {32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h7FFE_0000, 1'b1}  // R4 max*max
    };

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Issue one product and wait for done; optional mid-run start with other operands
    task automatic run_mult(input logic [N-1:0] a, input logic [N-1:0] b, input bit poke);
        @(negedge clk);
        mcand = a; mplr = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
            if (poke && lat == 5) begin
                mcand = 32'h0003_0000; mplr = 32'h8002_0000; start = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R8 result reset", result, '0);
        check("R8 done reset", {31'b0, done}, '0);
        check("R8 ovf reset", {31'b0, overflow}, '0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            run_mult(VEC[i][96:65], VEC[i][64:33], 1'b0);
            check($sformatf("R1 R2 R3 result vec%0d", i), result, VEC[i][32:1]);
            check($sformatf("R4 overflow vec%0d", i), {31'b0, overflow}, {31'b0, VEC[i][0]});
            check($sformatf("R5 latency vec%0d", i), lat, N);
        end

        // R5: done lasts one cycle
        @(negedge clk);
        check("R5 done single", {31'b0, done}, '0);

        // R7: outputs hold with changing inputs and start low
        mcand = 32'h1234_5678; mplr = 32'h0000_8000;
        repeat (10) @(negedge clk);
        check("R7 result held", result, 32'h7FFE_0000);
        check("R7 ovf held", {31'b0, overflow}, 32'd1);

        // R6: start during run is ignored
        run_mult(32'h0001_8000, 32'h8000_8000, 1'b1);
        check("R6 result unaffected", result, 32'h8001_8000);
        check("R6 ovf unaffected", {31'b0, overflow}, '0);
        check("R6 latency unaffected", lat, N);
        @(negedge clk);
        start = 1'b0;
        repeat (N + 4) @(negedge clk);
        check("R6 no extra done result", result, 32'h8001_8000);

        // R8: reset mid-run clears everything
        run_mult(32'h0000_8000, 32'h0002_0000, 1'b0);
        check("R1 4.0 result", result, 32'h0002_0000);
        @(negedge clk);
        mcand = 32'h0002_0000; mplr = 32'h0002_0000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R8 result after reset", result, '0);
        check("R8 done after reset", {31'b0, done}, '0);
        rst_n = 1'b1;
        repeat (N + 4) @(negedge clk);
        check("R8 idle after reset", {31'b0, done}, '0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule